// File: doc/BRIEF.md
# Decimator Output Status and Data-Ready Handshake

This block sits behind a decimating digital filter. Each time the filter produces an output word, it decides whether the word is loaded into the data register. It then drives a data-ready line toward an external serial reader. The line rises when a word is loaded. It falls once the reader has clocked out the least significant bit. If the previous word was never read, the line dips low for half a master-clock period, so that every newly loaded word still gives the reader a rising edge. When the filter reports an overwrite, the strobe loads no word and the line is left alone.

Alongside the handshake, the block keeps per-word status flags: a one-shot sync marker, a calibration-complete marker and overflow flags. It also builds an 8-bit configuration readback word. The readback word mirrors either the configuration pins or the host configuration bits, depending on a mode select. Finally, the block decodes the three decimation-select bits into the number of master clocks per output word.

The serial clock and the LSB marker come from the reader's domain. Both pass through a synchronizer of `SYNC_STAGES` flops before a falling serial-clock edge is recognised.

Top module: `dec_status_hs`

## Requirements
- R1: A synchronous active-high reset drives data-ready low and clears all flags, the readback word, the rate output and the reserved-code flag.
- R2: A load event is a word strobe with overwrite low. On the clock edge that samples a load event, data-ready goes high.
- R3: A serial read is a falling edge of the synchronized serial clock while the synchronized LSB marker is high. It clears data-ready on the edge `SYNC_STAGES` clocks after the edge that first samples the serial clock low.
- R4: If a load event occurs while data-ready is already high and no read is recognised in the same cycle, data-ready is low from that edge until the following falling master-clock edge, and high otherwise.
- R5: A word strobe with overwrite high loads nothing. Data-ready, the sync flag, the calibration flag and the overflow flags all keep their values.
- R6: When a load event and a read fall on the same edge, the load wins. Data-ready stays high and no low pulse is produced.
- R7: The sync flag is set by the second load event after a SYNC pulse and cleared by the next load event. A SYNC pulse on the same edge as a load event restarts the count, and that load is not counted.
- R8: The calibration flag takes the value of the calibration-done input at each load event and holds it until the next one.
- R9: The overflow flags take the value of the overflow input at each load event and hold it until the next one.
- R10: The readback word is registered one edge after its inputs. Its fields are: bit 7 power-down, bit 6 calibrate, bit 5 use-offset, bit 4 filter-source select, bits 2..0 decimation code. The fields come from the pin vector when the mode select is high and from the host vector when it is low. Both 7-bit vectors are packed with bit 6 power-down, bit 5 calibrate, bit 4 use-offset, bit 3 source, and bits 2..0 decimation code.
- R11: Readback bit 5 reads 0 on the edge after calibration-busy is high, and readback bit 3 always reads 0.
- R12: One edge after the inputs change, the selected decimation code k is decoded. For k from 1 to 7, the rate output is 2^(15-k) master clocks (16384 down to 256). Code 0 is reserved: the rate output reads 0 and the reserved flag reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| word_stb_i | input | 1 | One-cycle strobe at each decimator output word |
| ovwr_i | input | 1 | Overwrite: this strobe does not load a word |
| sclk_i | input | 1 | Serial clock from the reader (asynchronous) |
| lsb_i | input | 1 | High while the data-register LSB is shifted out |
| sync_i | input | 1 | SYNC pulse (master-clock domain) |
| cal_done_i | input | 1 | The word being loaded carries the calibrated offset |
| cal_busy_i | input | 1 | Calibration in progress |
| ovf_i | input | OVF_W | Overflow conditions for the word being loaded |
| hw_mode_i | input | 1 | 1: readback follows pins, 0: follows host bits |
| pin_cfg_i | input | 7 | Configuration pins |
| host_cfg_i | input | 7 | Host configuration bits |
| drdy_o | output | 1 | Data-ready line |
| sync_flag_o | output | 1 | One-shot sync marker |
| cal_flag_o | output | 1 | Calibration-complete marker |
| ovf_flag_o | output | OVF_W | Overflow flags of the current word |
| readback_o | output | 8 | Configuration readback word |
| rate_clks_o | output | 15 | Master clocks per output word |
| rate_rsvd_o | output | 1 | Reserved decimation code selected |

## Verification
Load effects on data-ready and on the flags appear right after the edge that samples the strobe. The readback word and the rate decode also follow their inputs by exactly one edge. A serial-clock fall reaches data-ready `SYNC_STAGES` edges after it is first sampled. The half-cycle dip exists only between a rising edge and the next falling edge. The bench's behavioural model keeps a sample history of the serial inputs, so that read detection lands on the right edge. Every output is compared 2 ns after each rising edge, and data-ready is compared again 7 ns after it, once the dip must be over.

// File: rtl/dsh_pkg.sv
package dsh_pkg;
    localparam int DEC_W  = 3;
    localparam int CFG_W  = 4 + DEC_W;
    localparam int RB_W   = 8;

    // readback bit positions
    localparam int RB_PWDN = 7;
    localparam int RB_CAL  = 6;
    localparam int RB_USE  = 5;
    localparam int RB_SRC  = 4;
    localparam int RB_RSV  = 3;

    typedef struct packed {
        logic             pwdn;
        logic             cal;
        logic             use_off;
        logic             src;
        logic [DEC_W-1:0] dec;
    } cfg_t;

    function automatic logic [RB_W-1:0] pack_readback(cfg_t c, logic busy);
        logic [RB_W-1:0] w;
        w          = '0;
        w[RB_PWDN] = c.pwdn;
        w[RB_CAL]  = c.cal;
        w[RB_USE]  = c.use_off & ~busy;
        w[RB_SRC]  = c.src;
        w[RB_RSV]  = 1'b0;
        w[DEC_W-1:0] = c.dec;
        return w;
    endfunction
endpackage

// File: rtl/dsh_rd_detect.sv
module dsh_rd_detect #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sclk_i,
    input  logic lsb_i,
    output logic rd_evt_o
);
    typedef struct packed {
        logic [STAGES-1:0] sc;
        logic [STAGES-1:0] lb;
        logic              prev;
    } st_t;

    st_t q, d;

    always_comb begin
        d      = q;
        d.sc   = {q.sc[STAGES-2:0], sclk_i};
        d.lb   = {q.lb[STAGES-2:0], lsb_i};
        d.prev = q.sc[STAGES-1];
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

    assign rd_evt_o = q.prev & ~q.sc[STAGES-1] & q.lb[STAGES-1];
endmodule

// File: rtl/dsh_ready_ctrl.sv
module dsh_ready_ctrl (
    input  logic clk,
    input  logic rst,
    input  logic load_i,
    input  logic rd_evt_i,
    output logic drdy_o
);
    typedef struct packed {
        logic rdy;
        logic tog;
    } st_t;

    st_t  q, d;
    logic tog_n_q;
    logic fire;

    assign fire = load_i & q.rdy & ~rd_evt_i;

    always_comb begin
        d = q;
        if (load_i)        d.rdy = 1'b1;
        else if (rd_evt_i) d.rdy = 1'b0;
        if (fire)          d.tog = ~q.tog;
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

    // falling-edge copy closes the low dip half a period after it opens
    always_ff @(negedge clk) begin
        if (rst) tog_n_q <= 1'b0;
        else     tog_n_q <= q.tog;
    end

    assign drdy_o = q.rdy & ~(q.tog ^ tog_n_q);

    // R2
    load_raise_chk: assert property (@(posedge clk) disable iff (rst)
        load_i |=> q.rdy);
    // R3
    read_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_evt_i && !load_i) |=> !q.rdy);
    // R5
    ready_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!load_i && !rd_evt_i) |=> $stable(q.rdy));
    // R6
    coincide_chk: assert property (@(posedge clk) disable iff (rst)
        (load_i && rd_evt_i) |=> $stable(q.tog));
endmodule

// File: rtl/dsh_flag_capture.sv
module dsh_flag_capture #(
    parameter int OVF_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic             sync_i,
    input  logic             cal_done_i,
    input  logic [OVF_W-1:0] ovf_i,
    output logic             sync_flag_o,
    output logic             cal_flag_o,
    output logic [OVF_W-1:0] ovf_flag_o
);
    localparam logic [1:0] CNT_IDLE = 2'd3;

    typedef struct packed {
        logic [1:0]       cnt;
        logic             sflag;
        logic             cflag;
        logic [OVF_W-1:0] ovf;
    } st_t;

    st_t q, d;

    always_comb begin
        d = q;
        if (load_i) begin
            d.sflag = (q.cnt == 2'd1) & ~sync_i;
            d.cflag = cal_done_i;
            d.ovf   = ovf_i;
        end
        if (sync_i)
            d.cnt = 2'd0;
        else if (load_i && q.cnt != CNT_IDLE)
            d.cnt = q.cnt + 2'd1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q     <= '0;
            q.cnt <= CNT_IDLE;
        end else begin
            q <= d;
        end
    end

    assign sync_flag_o = q.sflag;
    assign cal_flag_o  = q.cflag;
    assign ovf_flag_o  = q.ovf;

    // R7
    sync_once_chk: assert property (@(posedge clk) disable iff (rst)
        (q.sflag && load_i) |=> !q.sflag);
    // R8
    cal_cap_chk: assert property (@(posedge clk) disable iff (rst)
        load_i |=> (q.cflag == $past(cal_done_i)));
    // R9
    ovf_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !load_i |=> $stable(q.ovf));
endmodule

// File: rtl/dsh_readback.sv
module dsh_readback
    import dsh_pkg::*;
#(
    parameter int RATE_W = 15
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hw_mode_i,
    input  logic              cal_busy_i,
    input  logic [CFG_W-1:0]  pin_cfg_i,
    input  logic [CFG_W-1:0]  host_cfg_i,
    output logic [RB_W-1:0]   readback_o,
    output logic [RATE_W-1:0] rate_clks_o,
    output logic              rate_rsvd_o
);
    localparam int NCODE = 1 << DEC_W;

    typedef struct packed {
        logic [RB_W-1:0]   rb;
        logic [RATE_W-1:0] rate;
        logic              rsvd;
    } st_t;

    st_t  q, d;
    cfg_t sel;
    logic [RATE_W-1:0] rate_lut [NCODE];

    // one decoded rate per code; code 0 is reserved
    for (genvar k = 0; k < NCODE; k++) begin : g_rate
        if (k == 0) begin : g_rsv
            assign rate_lut[k] = '0;
        end else begin : g_val
            assign rate_lut[k] = RATE_W'(1) << (RATE_W - k);
        end
    end

    always_comb begin
        sel    = hw_mode_i ? cfg_t'(pin_cfg_i) : cfg_t'(host_cfg_i);
        d      = q;
        d.rb   = pack_readback(sel, cal_busy_i);
        d.rate = rate_lut[sel.dec];
        d.rsvd = (sel.dec == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

    assign readback_o  = q.rb;
    assign rate_clks_o = q.rate;
    assign rate_rsvd_o = q.rsvd;

    // R11
    busy_zero_chk: assert property (@(posedge clk) disable iff (rst)
        cal_busy_i |=> !q.rb[RB_USE]);
    // R12
    rsvd_rate_chk: assert property (@(posedge clk) disable iff (rst)
        q.rsvd |-> (q.rate == '0));
    // R10
    mode_pin_chk: assert property (@(posedge clk) disable iff (rst)
        hw_mode_i |=> (q.rb[DEC_W-1:0] == $past(pin_cfg_i[DEC_W-1:0])));
endmodule

// File: rtl/dec_status_hs.sv
module dec_status_hs
    import dsh_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int OVF_W       = 2,
    parameter int RATE_W      = 15
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              word_stb_i,
    input  logic              ovwr_i,
    input  logic              sclk_i,
    input  logic              lsb_i,
    input  logic              sync_i,
    input  logic              cal_done_i,
    input  logic              cal_busy_i,
    input  logic [OVF_W-1:0]  ovf_i,
    input  logic              hw_mode_i,
    input  logic [6:0]        pin_cfg_i,
    input  logic [6:0]        host_cfg_i,
    output logic              drdy_o,
    output logic              sync_flag_o,
    output logic              cal_flag_o,
    output logic [OVF_W-1:0]  ovf_flag_o,
    output logic [7:0]        readback_o,
    output logic [RATE_W-1:0] rate_clks_o,
    output logic              rate_rsvd_o
);
    logic load;
    logic rd_evt;

    assign load = word_stb_i & ~ovwr_i;

    dsh_rd_detect #(.STAGES(SYNC_STAGES)) u_rd (
        .clk      (clk),
        .rst      (rst),
        .sclk_i   (sclk_i),
        .lsb_i    (lsb_i),
        .rd_evt_o (rd_evt)
    );

    dsh_ready_ctrl u_rdy (
        .clk      (clk),
        .rst      (rst),
        .load_i   (load),
        .rd_evt_i (rd_evt),
        .drdy_o   (drdy_o)
    );

    dsh_flag_capture #(.OVF_W(OVF_W)) u_flags (
        .clk         (clk),
        .rst         (rst),
        .load_i      (load),
        .sync_i      (sync_i),
        .cal_done_i  (cal_done_i),
        .ovf_i       (ovf_i),
        .sync_flag_o (sync_flag_o),
        .cal_flag_o  (cal_flag_o),
        .ovf_flag_o  (ovf_flag_o)
    );

    dsh_readback #(.RATE_W(RATE_W)) u_rb (
        .clk         (clk),
        .rst         (rst),
        .hw_mode_i   (hw_mode_i),
        .cal_busy_i  (cal_busy_i),
        .pin_cfg_i   (pin_cfg_i),
        .host_cfg_i  (host_cfg_i),
        .readback_o  (readback_o),
        .rate_clks_o (rate_clks_o),
        .rate_rsvd_o (rate_rsvd_o)
    );
endmodule

// File: tb/dec_status_hs_bench.sv
module dec_status_hs_bench;
    localparam int S  = 2;
    localparam int OW = 2;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst = 1'b1;
    logic stb = 0, ovwr = 0, sclk = 1, lsb = 0, sync = 0, cdone = 0, busy = 0, hw = 0;
    logic [OW-1:0] ovf = '0;
    logic [6:0] pin = '0, host = '0;

    logic drdy, sflag, cflag, rsvd;
    logic [OW-1:0] oflag;
    logic [7:0] rb;
    logic [14:0] rate;

    dec_status_hs u_dec_status_hs (
        .clk(clk), .rst(rst), .word_stb_i(stb), .ovwr_i(ovwr), .sclk_i(sclk),
        .lsb_i(lsb), .sync_i(sync), .cal_done_i(cdone), .cal_busy_i(busy),
        .ovf_i(ovf), .hw_mode_i(hw), .pin_cfg_i(pin), .host_cfg_i(host),
        .drdy_o(drdy), .sync_flag_o(sflag), .cal_flag_o(cflag), .ovf_flag_o(oflag),
        .readback_o(rb), .rate_clks_o(rate), .rate_rsvd_o(rsvd)
    );

    int compared = 0, mismatched = 0;
    bit finished = 0;
    bit started  = 0;

    task automatic check(string req, string what, int act, int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
        end
    endtask

    // behavioural reference model
    bit m_rdy, m_dip, m_sf, m_cf, m_rsvd;
    bit [OW-1:0] m_ovf;
    int m_cnt = 3;
    bit [7:0] m_rb;
    int m_rate;
    bit sh[8];
    bit lh[8];

    always @(posedge clk) begin
        bit rd, ld, dip_sel;
        bit [6:0] c;
        if (rst) begin
            m_rdy = 0; m_dip = 0; m_sf = 0; m_cf = 0; m_ovf = '0; m_cnt = 3;
            m_rb = '0; m_rate = 0; m_rsvd = 0;
            for (int i = 0; i < 8; i++) begin sh[i] = 0; lh[i] = 0; end
        end else begin
            rd = sh[S] && !sh[S-1] && lh[S-1];
            ld = stb && !ovwr;
            m_dip = ld && m_rdy && !rd;
            if (ld) m_rdy = 1; else if (rd) m_rdy = 0;
            if (ld) begin
                m_sf  = (m_cnt == 1) && !sync;
                m_cf  = cdone;
                m_ovf = ovf;
            end
            if (sync) m_cnt = 0;
            else if (ld && m_cnt < 3) m_cnt = m_cnt + 1;
            for (int i = 7; i > 0; i--) begin sh[i] = sh[i-1]; lh[i] = lh[i-1]; end
            sh[0] = sclk; lh[0] = lsb;
            dip_sel = hw;
            c = dip_sel ? pin : host;
            m_rb = {c[6], c[5], c[4] & !busy, c[3], 1'b0, c[2:0]};
            m_rsvd = (c[2:0] == 0);
            m_rate = m_rsvd ? 0 : (1 << (15 - int'(c[2:0])));
        end
    end

    always @(posedge clk) begin
        if (started && !finished) begin
            #2;
            check("R2 R3 R4 R5 R6", "drdy_early", drdy, m_rdy && !m_dip);
            check("R7", "sync_flag", sflag, m_sf);
            check("R8", "cal_flag", cflag, m_cf);
            check("R9", "ovf_flags", oflag, m_ovf);
            check("R10 R11", "readback", rb, m_rb);
            check("R12", "rate", rate, m_rate);
            check("R12", "rate_rsvd", rsvd, m_rsvd);
            #5;
            check("R4", "drdy_late", drdy, m_rdy);
        end
    end

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic load_word(bit ow);
        @(negedge clk); stb = 1; ovwr = ow;
        @(negedge clk); stb = 0; ovwr = 0;
    endtask

    task automatic serial_read();
        @(negedge clk); lsb = 1; sclk = 0;
        cyc(4);
        sclk = 1; lsb = 0;
        cyc(2);
    endtask

    task automatic summary();
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            mismatched++;
            compared++;
            $display("FAIL watchdog expired actual=1 expected=0");
            summary();
        end
    end

    initial begin
        cyc(3);
        #3;
        // R1 reset state
        check("R1", "drdy_reset", drdy, 0);
        check("R1", "flags_reset", {sflag, cflag, oflag}, 0);
        check("R1", "readback_reset", rb, 0);
        check("R1", "rate_reset", {rate, rsvd}, 0);
        @(negedge clk); rst = 0; started = 1;
        host = 7'b0011_011; pin = 7'b1100_001;
        cyc(2);
        // R2 load then R3 read
        load_word(0); cyc(3);
        serial_read(); cyc(2);
        // R4 unread words
        load_word(0); cyc(3); load_word(0); cyc(3);
        // R5 overwrite
        cdone = 1; ovf = 2'b11; load_word(1); cdone = 0; ovf = 0; cyc(3);
        serial_read();
        // R7 sync then loads
        @(negedge clk); sync = 1; @(negedge clk); sync = 0;
        for (int i = 0; i < 4; i++) begin load_word(0); cyc(2); end
        // R8 R9 capture
        cdone = 1; ovf = 2'b10; load_word(0); cdone = 0; ovf = 0; cyc(2);
        // R10 R11 R12 readback modes
        hw = 1; cyc(2); busy = 1; pin[4] = 1; cyc(2); busy = 0;
        for (int k = 0; k < 8; k++) begin pin[2:0] = 3'(k); cyc(2); end
        hw = 0;
        for (int k = 0; k < 8; k++) begin host[2:0] = 3'(k); cyc(2); end
        // randomized traffic for coincidences (R6 and others)
        for (int n = 0; n < 4000; n++) begin
            @(negedge clk);
            stb   = ($urandom % 4) == 0;
            ovwr  = ($urandom % 5) == 0;
            sclk  = $urandom % 2;
            lsb   = ($urandom % 3) == 0;
            sync  = ($urandom % 25) == 0;
            cdone = $urandom % 2;
            busy  = ($urandom % 4) == 0;
            ovf   = OW'($urandom);
            hw    = $urandom % 2;
            pin   = 7'($urandom);
            host  = 7'($urandom);
        end
        @(negedge clk); stb = 0; sync = 0;
        cyc(4);
        summary();
    end
endmodule